// File: doc/BRIEF.md
# Banked Register Page Selector with Slot Save and Restore

This block holds the page number that chooses which bank of a peripheral's registers is visible through a shared address window. The current page drives the bank decode of the peripheral; the banked registers themselves sit outside this block.

Software controls the page with a single byte write. The byte carries an operation code, a slot index and a page value. Depending on the operation code the write sets the page directly, stores the present page in one of four hidden slots while loading a new page, or brings a page back from one of those slots. An interrupt handler can therefore switch to its own page on entry and return to the interrupted page on exit, each with one write and no read-modify-write sequence.

Top module: `pgsel_top`

## Requirements
- R1: After reset the current page is 0 and all four slots hold 0, so a restore from any slot before any save yields page 0.
- R2: A write whose operation code (bits 7:6) is 00 or 01 copies the page field (bits 2:0) into the current page and leaves every slot unchanged.
- R3: A write with operation code 10 stores the current page into the slot chosen by bits 5:4 (00, 01, 10, 11 pick slots 0 to 3) and loads the page field into the current page.
- R4: A write with operation code 11 loads the current page from the slot chosen by bits 5:4; the page field of the written byte has no effect.
- R5: The read port returns the current page in bits 2:0 and 0 in bits 7:3.
- R6: Without a write strobe the current page and the slots keep their values.
- R7: The current page takes its new value at the clock edge that samples the write, so a restore written in the cycle right after a save already returns the saved page.
- R8: The four slots are independent: saves into different slots nest, and restores in reverse order return each earlier page in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| wrData | input | 8 | Written byte: operation [7:6], slot [5:4], reserved [3], page [2:0] |
| rdData | output | 8 | Read value: current page in [2:0], zeros elsewhere |
| curPage | output | 3 | Current page, drives the bank decode |

## Verification
Every write takes effect at the edge that samples it, so the current page and the read value are due one edge after the write strobe is presented and are sampled on the following falling edge. Writes issued by consecutive calls land in consecutive cycles, which exercises a restore in the cycle directly after a save. Slot contents are observed only through later restores, and checks after idle cycles confirm that nothing moves without a strobe.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;
  localparam int PAGE_W  = 3;
  localparam int SLOTS   = 4;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int DATA_W  = 8;
  localparam int OP_HI   = 7;
  localparam int OP_LO   = 6;
  localparam int SLOT_HI = 5;
  localparam int SLOT_LO = 4;

  typedef struct packed {
    logic              loadNew;
    logic              saveCur;
    logic              restore;
    logic [SLOT_W-1:0] slotIdx;
    logic [PAGE_W-1:0] newPage;
  } pgStrobes_t;
endpackage

// File: rtl/pgsel_ctrl.sv
module pgsel_ctrl
  import pgsel_pkg::*;
(
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output pgStrobes_t        strobes
);
  logic [1:0] opCode;

  always_comb begin
    opCode          = wrData[OP_HI:OP_LO];
    strobes.slotIdx = wrData[SLOT_HI:SLOT_LO];
    strobes.newPage = wrData[PAGE_W-1:0];
    strobes.loadNew = wrEn && (opCode != 2'b11);
    strobes.saveCur = wrEn && (opCode == 2'b10);
    strobes.restore = wrEn && (opCode == 2'b11);
  end
endmodule

// File: rtl/pgsel_datapath.sv
module pgsel_datapath
  import pgsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobes_t        strobes,
  output logic [PAGE_W-1:0] pageQ
);
  logic [PAGE_W-1:0] slotQ [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ[s] <= '0;
      else if (strobes.saveCur && (strobes.slotIdx == SLOT_W'(s)))
        slotQ[s] <= pageQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pageQ <= '0;
    else if (strobes.restore)
      pageQ <= slotQ[strobes.slotIdx];
    else if (strobes.loadNew)
      pageQ <= strobes.newPage;
  end
endmodule

// File: rtl/pgsel_top.sv
module pgsel_top
  import pgsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [2:0]        curPage
);
  pgStrobes_t strobes;

  pgsel_ctrl uCtrl (
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobes (strobes)
  );

  pgsel_datapath uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pageQ   (curPage)
  );

  assign rdData = {{(DATA_W-PAGE_W){1'b0}}, curPage};
endmodule

// File: rtl/pgsel_chk.sv
module pgsel_chk
  import pgsel_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [2:0] curPage
);
  logic [PAGE_W-1:0] shadow [SLOTS];
  logic [PAGE_W-1:0] shadowSel;
  logic [1:0]        opSeen;

  assign opSeen    = wrData[OP_HI:OP_LO];
  assign shadowSel = shadow[wrData[SLOT_HI:SLOT_LO]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) shadow[i] <= '0;
    end else if (wrEn && opSeen == 2'b10) begin
      shadow[wrData[SLOT_HI:SLOT_LO]] <= curPage;
    end
  end

  assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !opSeen[1]) |=> (curPage == $past(wrData[PAGE_W-1:0])));

  assert_save_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opSeen == 2'b10) |=> (curPage == $past(wrData[PAGE_W-1:0])));

  assert_restore_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opSeen == 2'b11) |=> (curPage == $past(shadowSel)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(curPage));

  assert_read_page_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[PAGE_W-1:0] == curPage) && (rdData[7:PAGE_W] == '0));
endmodule

bind pgsel_top pgsel_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .curPage (curPage)
);

// File: tb/tb_pgsel_top.sv
module tb_pgsel_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [2:0] curPage;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pgsel_top dut (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .curPage (curPage)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write per call; consecutive calls give writes in consecutive cycles
  task automatic wr(input logic [1:0] op, input logic [1:0] slot, input logic [2:0] pg);
    wrEn   = 1'b1;
    wrData = {op, slot, 1'b0, pg};
    @(posedge clk);
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = 8'hff;
  endtask

  task automatic testReset();
    check("R1 page", {5'b0, curPage}, 8'h00);
    check("R5 read", rdData, 8'h00);
    wr(2'b11, 2'b10, 3'b101);
    check("R1 slot2 restore", {5'b0, curPage}, 8'h00);
  endtask

  task automatic testDirect();
    wr(2'b00, 2'b00, 3'd5);
    check("R2 op00", {5'b0, curPage}, 8'h05);
    check("R5 read", rdData, 8'h05);
    wr(2'b01, 2'b11, 3'd3);
    check("R2 op01", {5'b0, curPage}, 8'h03);
    // slot 3 untouched by direct writes
    wr(2'b11, 2'b11, 3'd6);
    check("R2 slot untouched", {5'b0, curPage}, 8'h00);
  endtask

  task automatic testSaveRestore();
    wr(2'b00, 2'b00, 3'd6);
    wr(2'b10, 2'b01, 3'd2);
    check("R3 load", {5'b0, curPage}, 8'h02);
    wr(2'b00, 2'b00, 3'd4);
    wr(2'b11, 2'b01, 3'd7);
    check("R4 restore ignores page", {5'b0, curPage}, 8'h06);
    check("R5 read", rdData, 8'h06);
  endtask

  task automatic testIdle();
    repeat (5) @(negedge clk);
    check("R6 idle hold", {5'b0, curPage}, 8'h06);
    wr(2'b11, 2'b01, 3'd0);
    check("R6 slot kept", {5'b0, curPage}, 8'h06);
  endtask

  task automatic testNested();
    wr(2'b00, 2'b00, 3'd1);
    wr(2'b10, 2'b00, 3'd4);
    check("R8 first save", {5'b0, curPage}, 8'h04);
    wr(2'b10, 2'b11, 3'd7);
    check("R8 second save", {5'b0, curPage}, 8'h07);
    wr(2'b11, 2'b11, 3'd0);
    check("R8 inner restore", {5'b0, curPage}, 8'h04);
    wr(2'b11, 2'b00, 3'd0);
    check("R8 outer restore", {5'b0, curPage}, 8'h01);
  endtask

  task automatic testBackToBack();
    wr(2'b00, 2'b00, 3'd3);
    wr(2'b10, 2'b10, 3'd5);
    wr(2'b11, 2'b10, 3'd1);
    check("R7 immediate restore", {5'b0, curPage}, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testSaveRestore();
    testIdle();
    testNested();
    testBackToBack();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule